// File: doc/BRIEF.md
# Sticky Alarm Trap Register

This block keeps one sticky status bit for every alarm source of a monitoring front end. The bits are grouped into four byte-wide registers. A host reads these registers through a plain register port that has an address, a write enable, write data and combinational read data. When an alarm line is high on a clock edge, its trap bit is set. The capture does not depend on any masking applied elsewhere, so the bank records every cause that has ever fired.

The host clears a bit by writing a 0 into that bit position. Writing a 1 to a bit leaves it as it was.

When the safety controller shuts the output stage down, the shutdown itself triggers further alarms. A shutdown-active input therefore freezes capture, so the bits that caused the shutdown remain readable and are not buried under these secondary alarms. Host clears keep working while capture is frozen.

Top module: `alarm_trap_bank`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every trap bit reads 0.
- R2: Alarm line k high on a clock edge where capture is enabled sets trap bit k. Bit k is read as bit k mod 8 of the register at address BASE_ADDR + k/8 (default BASE_ADDR is 0x40).
- R3: A set trap bit stays set after its alarm line returns low.
- R4: A write to a register in the window clears every bit that is written as 0. Every bit written as 1 keeps its value.
- R5: If a clear and an alarm hit the same bit on the same edge, the bit ends up set.
- R6: Capture stays enabled on the first edge where shutdown is sampled high. It is disabled on every later edge while shutdown stays high.
- R7: Capture resumes on the first edge where shutdown is sampled low again.
- R8: Host clears still take effect while capture is frozen by shutdown.
- R9: Writes to addresses outside BASE_ADDR..BASE_ADDR+3 change no bit, and reads of such addresses return 0.
- R10: Reads are combinational and have no side effect. Reading a register any number of times leaves its contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_i | input | 32 | Raw alarm lines, one per trap bit |
| shutdown_i | input | 1 | Safety shutdown active |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data (0 bits clear) |
| rdata_o | output | 8 | Read data for addr_i |

## Verification
Two things can happen to the same bit on the same edge: the host can clear it while its alarm line is also high. The table drives both cases in a single step. In one case the alarm and the cleared bit are on different bits. In the other they are on the same bit, and the expected result is a set bit.

A second overlap is shutdown rising on the same edge as a new alarm. The expected readback shows that alarm captured. The next alarm, which arrives while shutdown is held, is expected to be dropped.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned TRAP_REG_W = 8;
  typedef logic [TRAP_REG_W-1:0] trap_byte_t;

  // Bits written as 0 by a hitting write are to be cleared
  function automatic trap_byte_t clear_mask(input logic sel, input trap_byte_t wdata);
    return sel ? ~wdata : '0;
  endfunction

  // Clear first, then set: a concurrent alarm wins
  function automatic trap_byte_t trap_next(input trap_byte_t cur, input trap_byte_t alarm,
                                           input logic cap_en, input trap_byte_t clr);
    return (cur & ~clr) | (cap_en ? alarm : '0);
  endfunction

  // Frozen only once shutdown has been seen on two consecutive edges
  function automatic logic capture_allowed(input logic sd_now, input logic sd_prev);
    return !(sd_now && sd_prev);
  endfunction
endpackage

// File: rtl/trap_window.sv
module trap_window #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_REGS  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] offset_w;

  always_comb begin
    offset_w = addr_i - BASE_ADDR;
    hit_o    = (offset_w < ADDR_W'(NUM_REGS));
    idx_o    = offset_w[IDX_W-1:0];
  end
endmodule

// File: rtl/trap_cell.sv
module trap_cell
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trap_byte_t alarm_i,
  input  logic       cap_en_i,
  input  trap_byte_t clr_i,
  output trap_byte_t trap_o
);
  trap_byte_t trap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) trap_q <= '0;
    else        trap_q <= trap_next(trap_q, alarm_i, cap_en_i, clr_i);
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/alarm_trap_bank.sv
module alarm_trap_bank
  import trap_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  localparam int unsigned N_ALARM = NUM_REGS * TRAP_REG_W,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_ALARM-1:0]    alarm_i,
  input  logic                  shutdown_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [TRAP_REG_W-1:0] wdata_i,
  output logic [TRAP_REG_W-1:0] rdata_o
);
  // Named internal events (observed by the checker)
  logic               shutdown_q;
  logic               cap_en_w;
  logic               win_hit_w;
  logic [IDX_W-1:0]   win_idx_w;
  logic [N_ALARM-1:0] clr_flat_w;
  logic [N_ALARM-1:0] trap_flat_w;
  trap_byte_t         trap_arr [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) shutdown_q <= 1'b0;
    else        shutdown_q <= shutdown_i;
  end

  assign cap_en_w = capture_allowed(shutdown_i, shutdown_q);

  trap_window #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR)
  ) u_window (
    .addr_i(addr_i),
    .hit_o (win_hit_w),
    .idx_o (win_idx_w)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic sel_w;
    assign sel_w = wr_en_i && win_hit_w && (win_idx_w == IDX_W'(k));
    assign clr_flat_w[k*TRAP_REG_W +: TRAP_REG_W] = clear_mask(sel_w, wdata_i);

    trap_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .alarm_i (alarm_i[k*TRAP_REG_W +: TRAP_REG_W]),
      .cap_en_i(cap_en_w),
      .clr_i   (clr_flat_w[k*TRAP_REG_W +: TRAP_REG_W]),
      .trap_o  (trap_arr[k])
    );
    assign trap_flat_w[k*TRAP_REG_W +: TRAP_REG_W] = trap_arr[k];
  end

  always_comb begin
    rdata_o = '0;
    if (win_hit_w) rdata_o = trap_arr[win_idx_w];
  end
endmodule

// File: rtl/alarm_trap_chk.sv
module alarm_trap_chk #(
  parameter int unsigned N_ALARM = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_ALARM-1:0] alarm_i,
  input logic               shutdown_i,
  input logic               wr_en_i,
  input logic [7:0]         rdata_o,
  input logic               win_hit_w,
  input logic               cap_en_w,
  input logic [N_ALARM-1:0] clr_flat_w,
  input logic [N_ALARM-1:0] trap_flat_w
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (trap_flat_w == '0));

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_w |=> ((trap_flat_w & $past(alarm_i)) == $past(alarm_i)));  // also R5

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(trap_flat_w) & ~$past(clr_flat_w)) & ~trap_flat_w) == '0));

  a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_i && $past(shutdown_i) && $past(rst_n)) |-> !cap_en_w);

  a_r6_no_new_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_w |=> ((trap_flat_w & ~$past(trap_flat_w)) == '0));

  a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit_w |-> (rdata_o == '0));

  a_r9_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !win_hit_w) |-> (clr_flat_w == '0));
endmodule

bind alarm_trap_bank alarm_trap_chk #(.N_ALARM(N_ALARM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alarm_i    (alarm_i),
  .shutdown_i (shutdown_i),
  .wr_en_i    (wr_en_i),
  .rdata_o    (rdata_o),
  .win_hit_w  (win_hit_w),
  .cap_en_w   (cap_en_w),
  .clr_flat_w (clr_flat_w),
  .trap_flat_w(trap_flat_w)
);

// File: tb/test_alarm_trap_bank.sv
`timescale 1ns/1ps
module test_alarm_trap_bank;
  localparam logic [7:0] BASE = 8'h40;

  typedef struct packed {
    logic [31:0] alarm;
    logic        sd;
    logic        wr;
    logic [7:0]  addr;
    logic [7:0]  wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 13;
  localparam step_t TBL [NSTEP] = '{
    '{32'h0000_0001, 1'b0, 1'b0, 8'h00, 8'h00, 32'h0000_0001, 4'd2},  // R2 first capture
    '{32'h8000_0100, 1'b0, 1'b0, 8'h00, 8'h00, 32'h8000_0101, 4'd2},  // R2 other bytes
    '{32'h0000_0000, 1'b0, 1'b0, 8'h00, 8'h00, 32'h8000_0101, 4'd3},  // R3 sticky
    '{32'h0000_0000, 1'b0, 1'b1, 8'h40, 8'hFE, 32'h8000_0100, 4'd4},  // R4 clear bit0
    '{32'h0000_0000, 1'b0, 1'b1, 8'h41, 8'hFF, 32'h8000_0100, 4'd4},  // R4 ones keep
    '{32'h0000_0200, 1'b0, 1'b1, 8'h41, 8'h00, 32'h8000_0200, 4'd5},  // R5 clear + other alarm
    '{32'h8000_0000, 1'b0, 1'b1, 8'h43, 8'h00, 32'h8000_0200, 4'd5},  // R5 same bit set wins
    '{32'h0001_0000, 1'b1, 1'b0, 8'h00, 8'h00, 32'h8001_0200, 4'd6},  // R6 first sd edge captures
    '{32'h0002_0000, 1'b1, 1'b0, 8'h00, 8'h00, 32'h8001_0200, 4'd6},  // R6 frozen
    '{32'h0000_0000, 1'b1, 1'b1, 8'h42, 8'h00, 32'h8000_0200, 4'd8},  // R8 clear while frozen
    '{32'h0004_0000, 1'b0, 1'b0, 8'h00, 8'h00, 32'h8004_0200, 4'd7},  // R7 resume
    '{32'h0000_0000, 1'b0, 1'b1, 8'h44, 8'h00, 32'h8004_0200, 4'd9},  // R9 write above window
    '{32'h0000_0000, 1'b0, 1'b1, 8'h3F, 8'h00, 32'h8004_0200, 4'd9}   // R9 write below window
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] alarm;
  logic        sd;
  logic [7:0]  addr;
  logic        wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alarm_trap_bank i_alarm_trap_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .alarm_i   (alarm),
    .shutdown_i(sd),
    .addr_i    (addr),
    .wr_en_i   (wr),
    .wdata_i   (wdata),
    .rdata_o   (rdata)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic read_all(input logic [31:0] exp, input string tag);
    for (int k = 0; k < 4; k++) begin
      addr = BASE + 8'(k);
      #0.3;
      check(rdata, exp[k*8 +: 8], $sformatf("%s byte%0d", tag, k));
    end
  endtask

  initial begin
    rst_n = 1'b0; alarm = '0; sd = 1'b0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    read_all(32'h0, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #0.5;
    read_all(32'h0, "R1 after release");

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      alarm = TBL[i].alarm; sd = TBL[i].sd; wr = TBL[i].wr;
      addr = TBL[i].addr; wdata = TBL[i].wdata;
      @(posedge clk); #0.5;
      alarm = '0; wr = 1'b0;
      read_all(TBL[i].exp, $sformatf("R%0d step%0d", TBL[i].req, i));
    end

    // R9 out-of-window reads return 0
    @(negedge clk);
    addr = 8'h44; #0.3; check(rdata, 8'h00, "R9 read 0x44");
    addr = 8'h3F; #0.3; check(rdata, 8'h00, "R9 read 0x3F");
    addr = 8'hFF; #0.3; check(rdata, 8'h00, "R9 read 0xFF");

    // R10 repeated reads over several edges leave contents unchanged
    addr = BASE + 8'd3;
    repeat (4) @(negedge clk);
    read_all(32'h8004_0200, "R10 after reads");

    // R1 reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #0.5;
    read_all(32'h0, "R1 mid-run reset");
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule